// File: doc/BRIEF.md
# Gated Processor Clock Divider

This block turns a selected source clock into a clock enable for the processor domain. The processor logic runs on the source clock and advances only in cycles where `cpu_en` is high. A 2-bit select picks one of four division ratios: /1, /2, /8 or /256. The codes do not map to the ratios in rising order. The block produces one enable pulse per division period, and each pulse is one source cycle wide.

Two conditions hold the enable low: an asserted power-down bit, or a wake-up delay that has not yet completed. While either one holds, the processor stops where it is. Only the enable is withheld, so every processor register keeps its value. When gating is released, the divider restarts from zero, and the first pulse comes a full division period later.

A new select value is taken up only at the end of the current division period, or while the output is gated. Because of this, a period in progress is never shortened or stretched.

Top module: `pclk_div`

## Requirements
- R1: While `rst` is high at a rising edge, `cpu_en` is low after that edge. After reset the active ratio is /1, so with gating released the first edge after reset produces a pulse, whatever `div_sel` holds.
- R2: Select code 2'b01 gives a ratio of /1: `cpu_en` is high in every cycle while ungated.
- R3: Select code 2'b00 gives /2: consecutive pulses are 2 cycles apart and each pulse is 1 cycle wide.
- R4: Select code 2'b10 gives /8: consecutive pulses are 8 cycles apart.
- R5: Select code 2'b11 gives /256: consecutive pulses are 256 cycles apart.
- R6: If `pwr_down` is high at a rising edge, `cpu_en` is low after that edge.
- R7: If `wake_done` is low at a rising edge, `cpu_en` is low after that edge.
- R8: After gating is released, the ratio N is the `div_sel` value sampled at the last gated edge. The first pulse appears after the N-th consecutive ungated edge.
- R9: A change of `div_sel` between pulses has no effect on the period in progress. The new ratio applies from the edge that ends that period.
- R10: For every ratio other than /1, each pulse is exactly one cycle wide and is followed by a low cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Selected source clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | Ratio select: 00 /2, 01 /1, 10 /8, 11 /256 |
| pwr_down | input | 1 | High stops the processor enable |
| wake_done | input | 1 | High once the wake-up delay has finished |
| cpu_en | output | 1 | Processor clock enable pulse |

## Verification
A wrong divider count or a stale ratio register shows up as a pulse one or more cycles away from where it belongs. The worst case is a full /256 period, so the bench keeps an independent per-cycle model of the expected enable and compares it on every clock. A broken gate path shows at once: a pulse appears in the cycle after power-down rises or wake-up drops. A counter that does not restart on release shows at the first pulse after ungating. A ratio picked up mid-period distorts the very next pulse interval, which the bench measures directly.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    typedef enum logic [1:0] {
        DIV_HALF   = 2'b00,
        DIV_ONE    = 2'b01,
        DIV_EIGHTH = 2'b10,
        DIV_SLOW   = 2'b11
    } div_code_e;

    localparam int LOG2_HALF   = 1;
    localparam int LOG2_ONE    = 0;
    localparam int LOG2_EIGHTH = 3;
    localparam int LOG2_SLOW   = 8;
    localparam int CNT_W       = LOG2_SLOW;

    typedef logic [CNT_W-1:0] count_t;

    typedef struct packed {
        count_t cnt;
        logic   en;
    } div_state_t;

    // terminal count (ratio minus one) for a select code
    function automatic count_t term_of(div_code_e code);
        int lg;
        case (code)
            DIV_HALF:   lg = LOG2_HALF;
            DIV_ONE:    lg = LOG2_ONE;
            DIV_EIGHTH: lg = LOG2_EIGHTH;
            default:    lg = LOG2_SLOW;
        endcase
        return count_t'((1 << lg) - 1);
    endfunction

endpackage

// File: rtl/pclk_gate.sv
module pclk_gate (
    input  logic pwr_down,
    input  logic wake_done,
    output logic gate
);
    // the enable is withheld on power-down or while wake-up is pending
    assign gate = pwr_down | ~wake_done;
endmodule

// File: rtl/pclk_ratio_reg.sv
module pclk_ratio_reg
    import pclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic [1:0] sel_in,
    output div_code_e active,
    output count_t    term
);
    always_ff @(posedge clk) begin
        if (rst)
            active <= DIV_ONE;
        else if (load)
            active <= div_code_e'(sel_in);
    end

    assign term = term_of(active);

    // R1: reset leaves the /1 ratio active
    assert_reset_ratio_R1: assert property (@(posedge clk)
        rst |=> (active == DIV_ONE));

    // R9: the active ratio moves only on a boundary or while gated
    assert_hold_ratio_R9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active));
endmodule

// File: rtl/pclk_counter.sv
module pclk_counter
    import pclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   gate,
    input  count_t term,
    output logic   boundary,
    output logic   en
);
    div_state_t st, st_nx;

    assign boundary = ~gate && (st.cnt == term);

    always_comb begin
        st_nx = st;
        if (gate) begin
            st_nx.cnt = '0;
            st_nx.en  = 1'b0;
        end else if (boundary) begin
            st_nx.cnt = '0;
            st_nx.en  = 1'b1;
        end else begin
            st_nx.cnt = st.cnt + 1'b1;
            st_nx.en  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= '{cnt: '0, en: 1'b0};
        else
            st <= st_nx;
    end

    assign en = st.en;

    // R8: gating forces the divider back to zero
    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        gate |=> (st.cnt == '0));

    // R9: the count never passes the terminal of the active ratio
    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        st.cnt <= term);

    // R10: with a ratio above one, a pulse is followed by a low cycle
    assert_pulse_width_R10: assert property (@(posedge clk) disable iff (rst)
        (en && term != '0 && !gate) |=> !en);
endmodule

// File: rtl/pclk_div.sv
module pclk_div
    import pclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] div_sel,
    input  logic       pwr_down,
    input  logic       wake_done,
    output logic       cpu_en
);
    logic      gate;
    logic      boundary;
    div_code_e active;
    count_t    term;

    pclk_gate u_gate (
        .pwr_down  (pwr_down),
        .wake_done (wake_done),
        .gate      (gate)
    );

    pclk_ratio_reg u_ratio (
        .clk    (clk),
        .rst    (rst),
        .load   (gate | boundary),
        .sel_in (div_sel),
        .active (active),
        .term   (term)
    );

    pclk_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .gate     (gate),
        .term     (term),
        .boundary (boundary),
        .en       (cpu_en)
    );

    // R6: power-down silences the enable from the next cycle
    assert_pdn_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> !cpu_en);

    // R7: a pending wake-up delay silences the enable
    assert_wake_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !wake_done |=> !cpu_en);

    // R1: reset clears the enable
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !cpu_en);
endmodule

// File: tb/test_pclk_div.sv
module test_pclk_div;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] div_sel = 2'b00;
    logic       pwr_down = 1'b0;
    logic       wake_done = 1'b1;
    logic       cpu_en;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string cur_tag = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk;

    pclk_div i_pclk_div (
        .clk       (clk),
        .rst       (rst),
        .div_sel   (div_sel),
        .pwr_down  (pwr_down),
        .wake_done (wake_done),
        .cpu_en    (cpu_en)
    );

    function automatic int ratio(logic [1:0] s);
        case (s)
            2'b00:   return 2;
            2'b01:   return 1;
            2'b10:   return 8;
            default: return 256;
        endcase
    endfunction

    // behavioural reference: phase within period, active ratio, expected enable
    int m_act = 1;
    int m_ph  = 0;
    bit m_en  = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_act = 1; m_ph = 0; m_en = 1'b0;
        end else if (pwr_down || !wake_done) begin
            m_ph = 0; m_en = 1'b0; m_act = ratio(div_sel);
        end else if (m_ph == m_act - 1) begin
            m_en = 1'b1; m_ph = 0; m_act = ratio(div_sel);
        end else begin
            m_en = 1'b0; m_ph = m_ph + 1;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!done) check(cur_tag, int'(cpu_en), int'(m_en));
    end

    // cycles from one pulse to the next
    task automatic period(output int p);
        int guard = 0;
        while (cpu_en !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
        p = 0;
        do begin @(negedge clk); p++; end while (cpu_en !== 1'b1 && p < 2000);
    endtask

    task automatic quiet_span(string tag, int n);
        int hits = 0;
        for (int i = 0; i < n; i++) begin @(negedge clk); if (cpu_en) hits++; end
        check(tag, hits, 0);
    endtask

    initial begin
        int p;
        int w;
        // R1: low in reset, /1 active right after reset even with code 00
        repeat (4) @(negedge clk);
        check("R1", int'(cpu_en), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(cpu_en), 1);
        cur_tag = "R3";
        repeat (6) @(negedge clk);
        period(p); check("R3", p, 2);
        // R10: one-cycle width at /2
        while (!cpu_en) @(negedge clk);
        @(negedge clk); check("R10", int'(cpu_en), 0);

        cur_tag = "R2"; div_sel = 2'b01;
        repeat (4) @(negedge clk);
        w = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); w += int'(cpu_en); end
        check("R2", w, 10);

        cur_tag = "R4"; div_sel = 2'b10;
        repeat (3) @(negedge clk);
        period(p); check("R4", p, 8);
        period(p); check("R4", p, 8);

        cur_tag = "R5"; div_sel = 2'b11;
        period(p);
        period(p); check("R5", p, 256);

        // R9: switch to /1 just after a pulse; the running /256 period must finish
        cur_tag = "R9";
        while (!cpu_en) @(negedge clk);
        @(negedge clk); check("R10", int'(cpu_en), 0);
        repeat (20) @(negedge clk);
        div_sel = 2'b01;
        p = 21;
        while (!cpu_en && p < 2000) begin @(negedge clk); p++; end
        check("R9", p, 256);
        @(negedge clk); check("R9", int'(cpu_en), 1);

        // R6: power-down stops pulses
        cur_tag = "R6"; pwr_down = 1'b1;
        @(negedge clk);
        quiet_span("R6", 40);
        // R8: release at /8, first pulse after 8 ungated edges
        cur_tag = "R8"; div_sel = 2'b10;
        @(negedge clk);
        pwr_down = 1'b0;
        p = 0;
        do begin @(negedge clk); p++; end while (!cpu_en && p < 2000);
        check("R8", p, 8);

        // R7: wake-up pending stops pulses, then release at /2
        cur_tag = "R7"; wake_done = 1'b0; div_sel = 2'b11;
        @(negedge clk);
        quiet_span("R7", 300);
        div_sel = 2'b00;
        @(negedge clk);
        cur_tag = "R8"; wake_done = 1'b1;
        p = 0;
        do begin @(negedge clk); p++; end while (!cpu_en && p < 2000);
        check("R8", p, 2);

        // both gates together, then brief release in mid-period
        cur_tag = "R6"; div_sel = 2'b10; pwr_down = 1'b1; wake_done = 1'b0;
        quiet_span("R6", 10);
        pwr_down = 1'b0;
        quiet_span("R7", 10);
        wake_done = 1'b1;
        cur_tag = "R8";
        repeat (3) @(negedge clk);
        pwr_down = 1'b1;
        repeat (3) @(negedge clk);
        pwr_down = 1'b0;
        repeat (30) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cycles >= 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<200000 cycles", cycles);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule